// File: doc/BRIEF.md
# Banked Search-Area Memory with Per-Bank Enables

This block holds the search area of a motion estimator in eight narrow RAM banks. Each bank is 16 bits wide. An external-memory loader fills the banks one 16-bit word at a time. The estimator reads 32-bit words, one per cycle.

Adjacent banks are grouped in pairs. Bank 2k supplies the low half of pair k and bank 2k+1 supplies the high half. A read enables only the two banks of the addressed pair. A write enables only the one bank it targets. Every other bank stays disabled, so unused RAMs do not toggle.

A four-way pair multiplexer forms the output word. Its select is registered so that it lines up with the single cycle of RAM read latency. The per-bank enables are brought out as a port, so the bank activity can be observed from outside the block.

Top module: `srch_mem`

## Requirements
- R1: A write with `wrEn` high stores `wrData` into bank `wrAddr[8:6]` at word `wrAddr[5:0]`. When no read is active in the same cycle, exactly that one bit of `bankEn` is high.
- R2: A read with `rdEn` high at pair p = `rdAddr[7:6]` and word w = `rdAddr[5:0]` returns `{bank(2p+1)[w], bank(2p)[w]}` on `rdData` one clock later.
- R3: During a read cycle with no write, `bankEn` has exactly the two bits 2p and 2p+1 set.
- R4: Reads on consecutive cycles to different pairs each return their own word one cycle after being issued. The pair select follows the data, not the current address.
- R5: When neither `rdEn` nor `wrEn` is high, `bankEn` is all zeros.
- R6: `rdValid` is high in exactly the cycle after a cycle with `rdEn` high, and low otherwise.
- R7: When a read and a write hit the same bank and word in one cycle, the read returns the old data. A later read returns the new data.
- R8: `rdData` keeps its last value through cycles without a read, even if a write changes the memory behind it.
- R9: During reset, `bankEn`, `rdValid` and `rdData` are zero.
- R10: When a read and a write to a bank outside the read pair fall in one cycle, `bankEn` is the union of both enables (three bits set), and both accesses complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rdEn | input | 1 | Read request from the estimator |
| rdAddr | input | 8 | Pair select [7:6] and word [5:0] |
| wrEn | input | 1 | Write request from the loader |
| wrAddr | input | 9 | Bank select [8:6] and word [5:0] |
| wrData | input | 16 | Write data |
| rdData | output | 32 | Read word, one cycle after `rdEn` |
| rdValid | output | 1 | `rdData` holds a fresh word |
| bankEn | output | 8 | Per-bank enable, one bit per bank |

## Verification
The bench builds the block with its package defaults: eight banks of 64 words each, grouped into four pairs.

With only 512 locations, the bench fills every word of every bank and can check every write's enable pattern. It also reads every pair at its first and last word, which covers the corners of the address decode.

The small depth also keeps the harder cases short. These are back-to-back reads that hop between pairs, a read and a write colliding on the same location, and a read overlapping a write to another pair.

// File: rtl/srch_pkg.sv
package srch_pkg;
  localparam int unsigned BANK_W     = 16;
  localparam int unsigned BANK_NUM   = 8;
  localparam int unsigned BANK_DEPTH = 64;
  localparam int unsigned PAIR_BANKS = 2;

  localparam int unsigned PAIR_NUM   = BANK_NUM / PAIR_BANKS;
  localparam int unsigned PAIR_SEL_W = $clog2(PAIR_NUM);
  localparam int unsigned BANK_SEL_W = $clog2(BANK_NUM);
  localparam int unsigned WORD_AW    = $clog2(BANK_DEPTH);
  localparam int unsigned RD_AW      = PAIR_SEL_W + WORD_AW;
  localparam int unsigned WR_AW      = BANK_SEL_W + WORD_AW;
  localparam int unsigned RD_W       = BANK_W * PAIR_BANKS;

  typedef struct packed {
    logic [BANK_NUM-1:0]   bankRd;
    logic [BANK_NUM-1:0]   bankWr;
    logic [PAIR_SEL_W-1:0] muxSel;
    logic                  rdValid;
  } strobe_t;
endpackage

// File: rtl/srch_ctrl.sv
module srch_ctrl
  import srch_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdEn,
  input  logic [RD_AW-1:0] rdAddr,
  input  logic             wrEn,
  input  logic [WR_AW-1:0] wrAddr,
  output strobe_t          strobe
);
  logic [PAIR_SEL_W-1:0] rdPair;
  logic [BANK_SEL_W-1:0] wrBank;
  logic [PAIR_SEL_W-1:0] muxSelQ;
  logic                  rdValidQ;
  logic [BANK_NUM-1:0]   rdDec;
  logic [BANK_NUM-1:0]   wrDec;

  assign rdPair = rdAddr[RD_AW-1 -: PAIR_SEL_W];
  assign wrBank = wrAddr[WR_AW-1 -: BANK_SEL_W];

  // Read decode: every bank of the addressed pair, nothing else.
  for (genvar p = 0; p < PAIR_NUM; p++) begin : g_pair
    for (genvar k = 0; k < PAIR_BANKS; k++) begin : g_lane
      assign rdDec[p*PAIR_BANKS + k] = rdEn && (rdPair == PAIR_SEL_W'(p));
    end
  end

  // Write decode: a single bank.
  for (genvar b = 0; b < BANK_NUM; b++) begin : g_wr
    assign wrDec[b] = wrEn && (wrBank == BANK_SEL_W'(b));
  end

  // Select and valid follow the one-cycle RAM latency.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muxSelQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      rdValidQ <= rdEn;
      if (rdEn) muxSelQ <= rdPair;
    end
  end

  assign strobe.bankRd  = rdDec;
  assign strobe.bankWr  = wrDec;
  assign strobe.muxSel  = muxSelQ;
  assign strobe.rdValid = rdValidQ;

  p_sel_align_r4: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> (strobe.muxSel == $past(rdPair)))
    else $error("R4: mux select not aligned with read data");

  p_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !strobe.rdValid)
    else $error("R6: valid without a read");
endmodule

// File: rtl/srch_bank.sv
module srch_bank #(
  parameter  int unsigned W     = 16,
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rdEn,
  input  logic [AW-1:0] rdAddr,
  output logic [W-1:0]  rdData,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [W-1:0]  wrData
);
  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
  end

  // Nonblocking update: a same-cycle read sees the old contents.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     rdQ <= '0;
    else if (rdEn) rdQ <= mem[rdAddr];
  end

  assign rdData = rdQ;

  p_bank_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData))
    else $error("R8: bank output moved without a read");
endmodule

// File: rtl/srch_datapath.sv
module srch_datapath
  import srch_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            strobe,
  input  logic [WORD_AW-1:0] rdWord,
  input  logic [WORD_AW-1:0] wrWord,
  input  logic [BANK_W-1:0]  wrData,
  output logic [RD_W-1:0]    rdData
);
  logic [BANK_W-1:0] laneQ   [BANK_NUM];
  logic [RD_W-1:0]   pairWord[PAIR_NUM];

  for (genvar b = 0; b < BANK_NUM; b++) begin : g_bank
    srch_bank #(.W(BANK_W), .DEPTH(BANK_DEPTH)) u_bank (
      .clk    (clk),
      .rstN   (rstN),
      .rdEn   (strobe.bankRd[b]),
      .rdAddr (rdWord),
      .rdData (laneQ[b]),
      .wrEn   (strobe.bankWr[b]),
      .wrAddr (wrWord),
      .wrData (wrData)
    );
  end

  // Lower-numbered bank of a pair fills the low half of the word.
  for (genvar p = 0; p < PAIR_NUM; p++) begin : g_join
    for (genvar k = 0; k < PAIR_BANKS; k++) begin : g_half
      assign pairWord[p][k*BANK_W +: BANK_W] = laneQ[p*PAIR_BANKS + k];
    end
  end

  assign rdData = pairWord[strobe.muxSel];

  p_out_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.bankRd == '0) |=> $stable(rdData))
    else $error("R8: output changed with no read");
endmodule

// File: rtl/srch_mem.sv
module srch_mem
  import srch_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           rdEn,
  input  logic [srch_pkg::RD_AW-1:0]     rdAddr,
  input  logic                           wrEn,
  input  logic [srch_pkg::WR_AW-1:0]     wrAddr,
  input  logic [srch_pkg::BANK_W-1:0]    wrData,
  output logic [srch_pkg::RD_W-1:0]      rdData,
  output logic                           rdValid,
  output logic [srch_pkg::BANK_NUM-1:0]  bankEn
);
  strobe_t strobe;

  srch_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .rdEn   (rdEn),
    .rdAddr (rdAddr),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .strobe (strobe)
  );

  srch_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rdWord (rdAddr[WORD_AW-1:0]),
    .wrWord (wrAddr[WORD_AW-1:0]),
    .wrData (wrData),
    .rdData (rdData)
  );

  assign bankEn  = strobe.bankRd | strobe.bankWr;
  assign rdValid = strobe.rdValid;

  p_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!rdEn && !wrEn) |-> (bankEn == '0))
    else $error("R5: bank enabled while idle");

  p_pair_only_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn) |-> ($countones(bankEn) == PAIR_BANKS))
    else $error("R3: read enabled wrong number of banks");

  p_single_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !rdEn) |-> ($countones(bankEn) == 1))
    else $error("R1: write enabled wrong number of banks");

  p_overlap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn) |-> ($countones(bankEn) >= PAIR_BANKS &&
                        $countones(bankEn) <= PAIR_BANKS + 1))
    else $error("R10: overlapping access enabled wrong bank count");

  p_valid_r6: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid)
    else $error("R6: valid missing after read");
endmodule

// File: tb/srch_mem_bench.sv
module srch_mem_bench;
  localparam int NB = 8;
  localparam int ND = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdAddr = '0;
  logic        wrEn = 1'b0;
  logic [8:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic [7:0]  bankEn;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NB][ND];

  always #2 clk = ~clk;

  srch_mem u_srch_mem (
    .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdAddr(rdAddr), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdData(rdData), .rdValid(rdValid),
    .bankEn(bankEn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] pattern(input int b, input int w);
    return {b[3:0], 12'(w * 37 + b * 5 + 11)};
  endfunction

  function automatic logic [31:0] pairVal(input int p, input int w);
    return {model[2*p+1][w], model[2*p][w]};
  endfunction

  task automatic t_reset();
    #1;
    check("R9 bankEn", 32'(bankEn), 32'h0);
    check("R9 rdValid", 32'(rdValid), 32'h0);
    check("R9 rdData", rdData, 32'h0);
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic t_fill();
    for (int b = 0; b < NB; b++) begin
      for (int w = 0; w < ND; w++) begin
        @(negedge clk);
        wrEn = 1'b1; wrAddr = {3'(b), 6'(w)}; wrData = pattern(b, w);
        #1 check("R1 write enable", 32'(bankEn), 32'(8'(1) << b));
        model[b][w] = pattern(b, w);
      end
    end
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic t_reads();
    int words[4] = '{0, 1, 33, 63};
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        rdEn = 1'b1; rdAddr = {2'(p), 6'(words[i])};
        #1 check("R3 pair enable", 32'(bankEn), 32'(8'b11 << (2*p)));
        @(negedge clk); rdEn = 1'b0;
        check("R6 valid", 32'(rdValid), 32'h1);
        check("R2 read data", rdData, pairVal(p, words[i]));
      end
    end
  endtask

  task automatic t_back2back();
    int pairs[4] = '{3, 0, 2, 1};
    int words[4] = '{7, 63, 0, 20};
    for (int i = 0; i <= 4; i++) begin
      @(negedge clk);
      if (i > 0) check("R4 back-to-back", rdData, pairVal(pairs[i-1], words[i-1]));
      if (i < 4) begin
        rdEn = 1'b1; rdAddr = {2'(pairs[i]), 6'(words[i])};
      end else rdEn = 1'b0;
    end
  endtask

  task automatic t_idle_hold();
    logic [31:0] held;
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    #1 check("R5 idle enables", 32'(bankEn), 32'h0);
    check("R6 valid low", 32'(rdValid), 32'h0);
    held = rdData;
    // last read was pair 1 word 20: overwrite bank 2 word 20
    wrEn = 1'b1; wrAddr = {3'd2, 6'd20}; wrData = 16'hBEEF;
    @(negedge clk); wrEn = 1'b0;
    model[2][20] = 16'hBEEF;
    @(negedge clk); @(negedge clk);
    check("R8 hold", rdData, held);
    check("R5 idle enables after write", 32'(bankEn), 32'h0);
  endtask

  task automatic t_collision();
    logic [31:0] oldVal;
    @(negedge clk);
    oldVal = pairVal(2, 40);
    rdEn = 1'b1; rdAddr = {2'd2, 6'd40};
    wrEn = 1'b1; wrAddr = {3'd5, 6'd40}; wrData = 16'h1234;
    #1 check("R7 enables", 32'(bankEn), 32'h30);
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
    model[5][40] = 16'h1234;
    check("R7 old data", rdData, oldVal);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = {2'd2, 6'd40};
    @(negedge clk); rdEn = 1'b0;
    check("R7 new data", rdData, {16'h1234, model[4][40]});
  endtask

  task automatic t_overlap();
    @(negedge clk);
    rdEn = 1'b1; rdAddr = {2'd0, 6'd5};
    wrEn = 1'b1; wrAddr = {3'd6, 6'd9}; wrData = 16'hA5C3;
    #1 check("R10 union enables", 32'(bankEn), 32'h43);
    @(negedge clk);
    wrEn = 1'b0;
    model[6][9] = 16'hA5C3;
    check("R10 read data", rdData, pairVal(0, 5));
    rdAddr = {2'd3, 6'd9};
    @(negedge clk); rdEn = 1'b0;
    check("R10 written data", rdData, pairVal(3, 9));
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finishRun();
  end

  initial begin
    t_reset();
    t_fill();
    t_reads();
    t_back2back();
    t_idle_hold();
    t_collision();
    t_overlap();
    finishRun();
  end
endmodule